// File: doc/BRIEF.md
# Host Interrupt Request and Vector Logic

This block produces the host-facing interrupt requests of a byte-wide parallel host port. Two status conditions are inputs: receive data waiting and transmit space free. Each has its own enable. In combined mode the enabled conditions are ORed onto one request line. In split mode they drive a transmit request line and a receive request line instead, and the combined line stays low. All request outputs are registered, so each one follows its inputs one clock later.

The block also builds a host-readable status byte. This byte holds the two data conditions, a mirror of a flag owned by the DSP side, and a summary bit that shows whether any request output is asserted. The host has no way to change the flag mirror. The block also holds an 8-bit interrupt vector that only the host can read or write. Both hardware reset and software reset set the vector to 0x0F. While the combined request and the host acknowledge are both high, the vector is driven onto the host data bus, and this takes precedence over any register read.

Top module: `hirq_port`

## Requirements
- R1: With `dual_mode` low, `irq_any` becomes, one clock later, (`rx_full` AND `rx_en`) OR (`tx_empty` AND `tx_en`), and `irq_tx` and `irq_rx` are low.
- R2: With `dual_mode` high, `irq_tx` becomes `tx_empty` AND `tx_en` one clock later, `irq_rx` becomes `rx_full` AND `rx_en` one clock later, and `irq_any` is low.
- R3: Status byte (address 2) bit 7 reads 1 exactly when at least one of `irq_any`, `irq_tx` or `irq_rx` is high.
- R4: Status bit 4 shows `dsp_flag3` as captured on the previous clock. Host writes to address 2 change no status bit.
- R5: Status bits 2, 3, 5 and 6 always read 0.
- R6: The vector register holds 0x0F after `rst_n` is low and in the clock after `soft_rst` is high. `soft_rst` wins over a write in the same cycle.
- R7: A host write (`host_cs`, `host_wr`, address 3) loads `host_wdata` into the vector on that clock edge. A read of address 3 returns the vector.
- R8: While `irq_any` and `host_ack` are both high, `host_oe` is high and `host_rdata` equals the vector, even if a read of another address is in progress.
- R9: Without that acknowledge condition and without `host_cs` AND `host_rd`, `host_oe` is low and `host_rdata` is 0. Unmapped addresses read 0.
- R10: Status bit 0 shows `rx_full` and bit 1 shows `tx_empty`, each as captured on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset of the vector |
| rx_full | input | 1 | Receive bytes waiting |
| tx_empty | input | 1 | Transmit bytes free |
| rx_en | input | 1 | Receive request enable |
| tx_en | input | 1 | Transmit request enable |
| dual_mode | input | 1 | 1 = separate transmit/receive requests |
| dsp_flag3 | input | 1 | DSP-owned flag to mirror |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_ack | input | 1 | Host interrupt acknowledge |
| host_rdata | output | 8 | Host read data |
| host_oe | output | 1 | Read data bus drive enable |
| irq_any | output | 1 | Combined request |
| irq_tx | output | 1 | Transmit request (split mode) |
| irq_rx | output | 1 | Receive request (split mode) |

## Verification
The hardest case to reach from the ports is an acknowledge that collides with a status read while the combined request is high. It needs combined mode, an enabled source that has been active for one clock, and chip select, read and acknowledge all in the same cycle. The bench builds this state on purpose and also produces it in a long pseudo-random run, where a per-cycle reference model decides the expected bus owner. It also asserts acknowledge in split mode, where the vector must stay off the bus.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR = 3'd3;
  localparam logic [BYTE_W-1:0] VEC_INIT = 8'h0F;
  localparam int unsigned SB_RXF = 0;
  localparam int unsigned SB_TXE = 1;
  localparam int unsigned SB_FLAG3 = 4;
  localparam int unsigned SB_REQ = 7;

  typedef enum logic [1:0] {
    BUS_IDLE   = 2'd0,
    BUS_VECTOR = 2'd1,
    BUS_REG    = 2'd2
  } bus_src_e;
endpackage

// File: rtl/hirq_req_gen.sv
module hirq_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_full,
  input  logic tx_empty,
  input  logic rx_en,
  input  logic tx_en,
  input  logic dual_mode,
  output logic req_one,
  output logic req_tx,
  output logic req_rx
);
  logic rx_hit, tx_hit;
  logic one_d, tx_d, rx_d;

  always_comb begin
    rx_hit = rx_full & rx_en;
    tx_hit = tx_empty & tx_en;
    one_d  = ~dual_mode & (rx_hit | tx_hit);
    tx_d   = dual_mode & tx_hit;
    rx_d   = dual_mode & rx_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_one <= 1'b0;
      req_tx  <= 1'b0;
      req_rx  <= 1'b0;
    end else begin
      req_one <= one_d;
      req_tx  <= tx_d;
      req_rx  <= rx_d;
    end
  end
endmodule

// File: rtl/hirq_status.sv
module hirq_status
  import hirq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_full,
  input  logic          tx_empty,
  input  logic          dsp_flag3,
  input  logic          req_one,
  input  logic          req_tx,
  input  logic          req_rx,
  output logic [DW-1:0] status
);
  logic rxf_q, txe_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q  <= 1'b0;
      txe_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rxf_q  <= rx_full;
      txe_q  <= tx_empty;
      flag_q <= dsp_flag3;
    end
  end

  always_comb begin
    status           = '0;
    status[SB_RXF]   = rxf_q;
    status[SB_TXE]   = txe_q;
    status[SB_FLAG3] = flag_q;
    status[SB_REQ]   = req_one | req_tx | req_rx;
  end
endmodule

// File: rtl/hirq_vec.sv
module hirq_vec
  import hirq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          host_cs,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] vec_q
);
  logic          wr_hit;
  logic          vec_ce;
  logic [DW-1:0] vec_d;

  always_comb begin
    wr_hit = host_cs & host_wr & (host_addr == AW'(ADDR_VECTOR));
    vec_ce = soft_rst | wr_hit;
    vec_d  = soft_rst ? DW'(VEC_INIT) : host_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= DW'(VEC_INIT);
    end else if (vec_ce) begin
      vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/hirq_bus.sv
module hirq_bus
  import hirq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic          host_ack,
  input  logic          req_one,
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] vec_q,
  output logic [DW-1:0] host_rdata,
  output logic          host_oe
);
  bus_src_e      src;
  logic [DW-1:0] reg_val;

  always_comb begin
    if (req_one && host_ack)      src = BUS_VECTOR;
    else if (host_cs && host_rd)  src = BUS_REG;
    else                          src = BUS_IDLE;
  end

  always_comb begin
    case (host_addr)
      AW'(ADDR_STATUS): reg_val = status;
      AW'(ADDR_VECTOR): reg_val = vec_q;
      default:          reg_val = '0;
    endcase
  end

  always_comb begin
    case (src)
      BUS_VECTOR: begin host_rdata = vec_q;   host_oe = 1'b1; end
      BUS_REG:    begin host_rdata = reg_val; host_oe = 1'b1; end
      default:    begin host_rdata = '0;      host_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/hirq_port.sv
module hirq_port
  import hirq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          rx_full,
  input  logic          tx_empty,
  input  logic          rx_en,
  input  logic          tx_en,
  input  logic          dual_mode,
  input  logic          dsp_flag3,
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          host_oe,
  output logic          irq_any,
  output logic          irq_tx,
  output logic          irq_rx
);
  logic [DW-1:0] status;
  logic [DW-1:0] vec_q;

  hirq_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .tx_empty(tx_empty),
    .rx_en(rx_en), .tx_en(tx_en), .dual_mode(dual_mode),
    .req_one(irq_any), .req_tx(irq_tx), .req_rx(irq_rx)
  );

  hirq_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .rx_full(rx_full), .tx_empty(tx_empty),
    .dsp_flag3(dsp_flag3), .req_one(irq_any), .req_tx(irq_tx),
    .req_rx(irq_rx), .status(status)
  );

  hirq_vec #(.DW(DW), .AW(AW)) u_vec (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_cs(host_cs),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .vec_q(vec_q)
  );

  hirq_bus #(.DW(DW), .AW(AW)) u_bus (
    .host_cs(host_cs), .host_rd(host_rd), .host_addr(host_addr),
    .host_ack(host_ack), .req_one(irq_any), .status(status), .vec_q(vec_q),
    .host_rdata(host_rdata), .host_oe(host_oe)
  );
endmodule

// File: rtl/hirq_chk.sv
module hirq_chk
  import hirq_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          soft_rst,
  input logic          rx_full,
  input logic          tx_empty,
  input logic          rx_en,
  input logic          tx_en,
  input logic          dual_mode,
  input logic          host_cs,
  input logic          host_rd,
  input logic          host_wr,
  input logic [AW-1:0] host_addr,
  input logic [DW-1:0] host_wdata,
  input logic          host_ack,
  input logic [DW-1:0] host_rdata,
  input logic          host_oe,
  input logic          irq_any,
  input logic          irq_tx,
  input logic          irq_rx,
  input logic [DW-1:0] vec_q
);
  logic ack_win, stat_rd;
  assign ack_win = irq_any && host_ack;
  assign stat_rd = host_oe && !ack_win && host_addr == AW'(ADDR_STATUS);

  AST_COMB_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_any == (!$past(dual_mode) &&
      (($past(rx_full) && $past(rx_en)) || ($past(tx_empty) && $past(tx_en))))); // R1
  AST_SPLIT_TX: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_tx == ($past(dual_mode) && $past(tx_empty) && $past(tx_en))); // R2
  AST_SPLIT_RX: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_rx == ($past(dual_mode) && $past(rx_full) && $past(rx_en))); // R2
  AST_REQ_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> host_rdata[SB_REQ] == (irq_any || irq_tx || irq_rx)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (host_rdata[6:5] == 2'b00 && host_rdata[3:2] == 2'b00)); // R5
  AST_SOFT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> vec_q == DW'(VEC_INIT)); // R6
  AST_VEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_cs && host_wr && host_addr == AW'(ADDR_VECTOR) && !soft_rst)
      |=> vec_q == $past(host_wdata)); // R7
  AST_ACK_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_win |-> (host_oe && host_rdata == vec_q)); // R8
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_win && !(host_cs && host_rd)) |-> (!host_oe && host_rdata == '0)); // R9
endmodule

bind hirq_port hirq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_full(rx_full),
  .tx_empty(tx_empty), .rx_en(rx_en), .tx_en(tx_en), .dual_mode(dual_mode),
  .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
  .host_rdata(host_rdata), .host_oe(host_oe), .irq_any(irq_any),
  .irq_tx(irq_tx), .irq_rx(irq_rx), .vec_q(vec_q)
);

// File: tb/test_hirq_port.sv
module test_hirq_port;
  logic       clk = 1'b0;
  logic       rst_n, soft_rst, rx_full, tx_empty, rx_en, tx_en, dual_mode, dsp_flag3;
  logic       host_cs, host_rd, host_wr, host_ack;
  logic [2:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       host_oe, irq_any, irq_tx, irq_rx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural reference state
  bit       m_any, m_tx, m_rx, m_rxf, m_txe, m_flag;
  bit [7:0] m_vec;

  always #5 clk = ~clk;

  hirq_port i_hirq_port (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_full(rx_full),
    .tx_empty(tx_empty), .rx_en(rx_en), .tx_en(tx_en), .dual_mode(dual_mode),
    .dsp_flag3(dsp_flag3), .host_cs(host_cs), .host_rd(host_rd),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata), .host_oe(host_oe),
    .irq_any(irq_any), .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    bit [7:0] st, exp_d;
    bit       exp_oe;
    string    tag;
    st = 8'h00;
    st[0] = m_rxf; st[1] = m_txe; st[4] = m_flag; st[7] = m_any | m_tx | m_rx;
    if (m_any && host_ack) begin
      exp_oe = 1; exp_d = m_vec; tag = "R8 vector on acknowledge";
    end else if (host_cs && host_rd) begin
      exp_oe = 1;
      if (host_addr == 3'd2) begin exp_d = st; tag = "R3 R4 R5 R10 status read"; end
      else if (host_addr == 3'd3) begin exp_d = m_vec; tag = "R6 R7 vector read"; end
      else begin exp_d = 8'h00; tag = "R9 unmapped read"; end
    end else begin
      exp_oe = 0; exp_d = 8'h00; tag = "R9 idle bus";
    end
    chk(irq_any == m_any, "R1 irq_any", irq_any, m_any);
    chk({irq_tx, irq_rx} == {m_tx, m_rx}, "R2 irq_tx/irq_rx", {irq_tx, irq_rx}, {m_tx, m_rx});
    chk(host_oe == exp_oe, tag, host_oe, exp_oe);
    chk(host_rdata == exp_d, tag, host_rdata, exp_d);
  endtask

  // inputs are already applied; advance one clock, update model, compare
  task automatic step();
    bit rh, th;
    @(posedge clk);
    rh = rx_full & rx_en;
    th = tx_empty & tx_en;
    m_any = !dual_mode & (rh | th);
    m_tx  = dual_mode & th;
    m_rx  = dual_mode & rh;
    m_rxf = rx_full; m_txe = tx_empty; m_flag = dsp_flag3;
    if (soft_rst) m_vec = 8'h0F;
    else if (host_cs && host_wr && host_addr == 3'd3) m_vec = host_wdata;
    @(negedge clk);
    compare();
  endtask

  task automatic idle_bus();
    host_cs = 0; host_rd = 0; host_wr = 0; host_ack = 0; soft_rst = 0;
    host_addr = 3'd0; host_wdata = 8'h00;
  endtask

  task automatic rd(input bit [2:0] a);
    idle_bus(); host_cs = 1; host_rd = 1; host_addr = a;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rx_full = 0; tx_empty = 0; rx_en = 0; tx_en = 0;
    dual_mode = 0; dsp_flag3 = 0;
    idle_bus();
    m_any = 0; m_tx = 0; m_rx = 0; m_rxf = 0; m_txe = 0; m_flag = 0; m_vec = 8'h0F;
    repeat (3) @(negedge clk);
    rd(3'd3);
    #1;
    chk(host_rdata == 8'h0F, "R6 vector at hardware reset", host_rdata, 8'h0F);
    chk(irq_any == 0 && irq_tx == 0 && irq_rx == 0, "R1 R2 requests low in reset",
        {irq_any, irq_tx, irq_rx}, 0);
    @(negedge clk);
    rst_n = 1;
    step();

    // combined mode, every source/enable pattern
    for (int i = 0; i < 16; i++) begin
      {rx_full, tx_empty, rx_en, tx_en} = 4'(i);
      dual_mode = 0; rd(3'd2);
      step();
    end
    // split mode, every source/enable pattern
    for (int i = 0; i < 16; i++) begin
      {rx_full, tx_empty, rx_en, tx_en} = 4'(i);
      dual_mode = 1; rd(3'd2);
      step();
      if (i == 15) chk(host_rdata[7] == 1 && irq_any == 0,
                       "R2 R3 split request sets status bit 7", host_rdata, 8'h80);
    end

    // flag mirror and host write attempt to status
    dsp_flag3 = 1; rd(3'd2); step();
    chk(host_rdata[4] == 1, "R4 flag mirror high", host_rdata[4], 1);
    idle_bus(); host_cs = 1; host_wr = 1; host_addr = 3'd2; host_wdata = 8'hFF;
    dsp_flag3 = 0; rx_full = 0; tx_empty = 0;
    step();
    rd(3'd2); step();
    chk(host_rdata[6:2] == 5'b00000, "R4 R5 status write ignored", host_rdata, 8'h00);

    // vector write and readback
    idle_bus(); host_cs = 1; host_wr = 1; host_addr = 3'd3; host_wdata = 8'hA5; step();
    rd(3'd3); step();
    chk(host_rdata == 8'hA5, "R7 vector readback", host_rdata, 8'hA5);
    idle_bus(); host_cs = 1; host_wr = 1; host_addr = 3'd3; host_wdata = 8'h3C; step();
    // soft reset wins over simultaneous write
    idle_bus(); soft_rst = 1; host_cs = 1; host_wr = 1; host_addr = 3'd3; host_wdata = 8'h77;
    step();
    rd(3'd3); step();
    chk(host_rdata == 8'h0F, "R6 soft reset beats write", host_rdata, 8'h0F);
    idle_bus(); host_cs = 1; host_wr = 1; host_addr = 3'd3; host_wdata = 8'hC3; step();

    // acknowledge collides with status read in combined mode
    dual_mode = 0; rx_full = 1; rx_en = 1; tx_en = 0; idle_bus(); step();
    rd(3'd2); host_ack = 1;
    #1;
    chk(host_oe == 1 && host_rdata == 8'hC3, "R8 acknowledge beats status read", host_rdata, 8'hC3);
    step();
    // acknowledge in split mode does not drive
    dual_mode = 1; idle_bus(); step();
    host_ack = 1; step();
    chk(host_oe == 0, "R9 acknowledge ignored in split mode", host_oe, 0);

    // pseudo-random run
    begin
      bit [15:0] lf = 16'hACE1;
      for (int n = 0; n < 2000; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        {rx_full, tx_empty, rx_en, tx_en, dsp_flag3} = lf[4:0];
        dual_mode = (lf[15:13] == 3'b111);
        host_cs = lf[5]; host_rd = lf[6]; host_wr = lf[7] & ~lf[6];
        host_addr = {1'b0, lf[9:8]}; host_wdata = lf[15:8] ^ 8'(n);
        host_ack = lf[10]; soft_rst = (lf[14:11] == 4'hF);
        step();
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule